// File: doc/BRIEF.md
# Address Zone Chip-Select Translator

This block takes a host bus transaction that an external decoder has already matched against a set of address zones. It chooses which of two external chip selects, if either, should serve the transaction. It also rewrites the host address into the 28-bit address that the peripheral side uses. A zone-hit vector from the decoder identifies the matching zone. A small internal mapping register assigns one zone code to each chip select. When a strobe arrives, the block combines the zone-hit vector with the mapping register and registers the result.

If both chip selects answer the same zone, chip select 0 takes the transaction. A transaction in a zone that no chip select answers is not claimed. The translated address depends on the transaction type and the zone. I/O addresses are zero-extended. User-zone and 386-style BIOS memory addresses keep their low 28 bits. Legacy BIOS memory addresses keep their low 17 bits and have every upper bit set, which moves them to the top of the peripheral space.

Top module: `zone_cs_xlate`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cs_o`, `claim_o` and `xaddr_o` are cleared, and the mapping register is cleared to code 0 (none) for both selects.
- R2: The mapping codes are 3 bits per select: 0 none, 1 I/O zone A, 2 I/O zone B, 3 user zone, 4 386-style BIOS, 5 legacy BIOS. `map_wr_data[2:0]` holds the code for select 0 and `map_wr_data[5:2+1]` holds the code for select 1. `zone_hit` is one-hot, with bit 0 for I/O zone A, bit 1 for I/O zone B, bit 2 for the user zone, bit 3 for 386-style BIOS and bit 4 for legacy BIOS. A select whose code names the zone that hits is asserted in `cs_o` (bit 0 is select 0).
- R3: If both selects name the zone that hits, only `cs_o[0]` is asserted.
- R4: If neither select names the zone that hits, `claim_o` and `cs_o` stay 0 and `xaddr_o` keeps its previous value.
- R5: For an I/O transaction (`req_is_mem`=0), `xaddr_o` equals `req_addr[15:0]` with bits 27:16 cleared.
- R6: For a memory transaction in the user zone or the 386-style BIOS zone, `xaddr_o` equals `req_addr[27:0]`.
- R7: For a memory transaction in the legacy BIOS zone, `xaddr_o[16:0]` equals `req_addr[16:0]` and `xaddr_o[27:17]` are all 1.
- R8: The outputs update on the clock edge at which `req_valid` is high. `claim_o` is high for exactly one clock per claimed strobe. Without a strobe, `claim_o` and `cs_o` are 0.
- R9: A mapping write at the same edge as a strobe does not affect that strobe. The new codes apply from the next strobe.
- R10: Codes 0, 6 and 7 never assert a select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transaction strobe |
| req_is_mem | input | 1 | 1 for a memory transaction, 0 for I/O |
| req_addr | input | 32 | Host address |
| zone_hit | input | 5 | One-hot zone match flags from the decoder |
| map_wr_en | input | 1 | Mapping register write enable |
| map_wr_data | input | 6 | Zone codes for both selects |
| cs_o | output | 2 | Registered chip select vector, active high |
| claim_o | output | 1 | One-clock pulse for a claimed transaction |
| xaddr_o | output | 28 | Registered translated address |

## Verification
Every result of a strobe comes from a single register stage. `cs_o`, `claim_o` and `xaddr_o` therefore change at the rising edge where `req_valid` is high. The bench drives its inputs at falling edges and reads those outputs at the next falling edge. At the falling edge one clock later, it checks that the claim pulse and the select have returned to zero. A mapping write that coincides with a strobe is only checked through the outputs of that strobe and of the following strobe. The register is never read directly.

// File: rtl/zcs_pkg.sv
// Package zcs_pkg
// Shared constants and zone-code encoding for the zone chip-select translator.
// Assumes the decoder drives a one-hot zone vector in the bit order given here.
package zcs_pkg;

    localparam int unsigned NUM_ZONES   = 5;
    localparam int unsigned MAP_W       = 3;
    localparam int unsigned ZONE_IO_A   = 0;
    localparam int unsigned ZONE_IO_B   = 1;
    localparam int unsigned ZONE_USER   = 2;
    localparam int unsigned ZONE_BIOS   = 3;
    localparam int unsigned ZONE_LEGACY = 4;

    // A mapping code of z+1 selects zone bit z. Code 0 selects nothing.
    typedef enum logic [MAP_W-1:0] {
        MAP_NONE    = 3'd0,
        MAP_IO_A    = 3'd1,
        MAP_IO_B    = 3'd2,
        MAP_USER    = 3'd3,
        MAP_BIOS386 = 3'd4,
        MAP_LEGACY  = 3'd5
    } map_code_e;

endpackage

// File: rtl/zcs_map_reg.sv
// Module zcs_map_reg
// Holds one zone code per chip select. It is written as a whole word.
// Assumes: a write at a given edge is seen by the datapath only after that edge,
// so a strobe at the same edge still uses the old codes.
module zcs_map_reg #(
    parameter int unsigned NUM_CS = 2,
    parameter int unsigned MAP_W  = 3,
    localparam int unsigned WORD_W = NUM_CS * MAP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] map_o
);

    logic [WORD_W-1:0] map_q;

    // Capture a new mapping word, or clear it to "none" on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else if (wr_en) begin
            map_q <= wr_data;
        end
    end

    assign map_o = map_q;

endmodule

// File: rtl/zcs_select.sv
// Module zcs_select
// Matches each select's zone code against the one-hot zone flags.
// A fixed priority is applied: a lower select index wins.
// Assumes zone_hit_i is one-hot or zero. Codes above NUM_ZONES match nothing.
module zcs_select #(
    parameter int unsigned NUM_CS    = 2,
    parameter int unsigned NUM_ZONES = 5,
    parameter int unsigned MAP_W     = 3,
    localparam int unsigned WORD_W   = NUM_CS * MAP_W
) (
    input  logic [WORD_W-1:0]    map_i,
    input  logic [NUM_ZONES-1:0] zone_hit_i,
    output logic [NUM_CS-1:0]    sel_o,
    output logic                 any_o
);

    logic [NUM_CS-1:0] match;
    logic [NUM_CS:0]   taken;

    assign taken[0] = 1'b0;

    for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
        logic [MAP_W-1:0]     code;
        logic [NUM_ZONES-1:0] zone_sel;

        assign code = map_i[c*MAP_W +: MAP_W];

        for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
            // Decode this select's code into a zone bit (code z+1 -> zone z).
            assign zone_sel[z] = (code == MAP_W'(z + 1));
        end

        // The select matches when its decoded zone is the one that hit.
        assign match[c] = |(zone_sel & zone_hit_i);

        // Priority chain: grant only when no lower select already matched.
        assign sel_o[c]   = match[c] & ~taken[c];
        assign taken[c+1] = taken[c] | match[c];
    end

    assign any_o = taken[NUM_CS];

endmodule

// File: rtl/zcs_addr_xlate.sv
// Module zcs_addr_xlate
// Rewrites a host address into the peripheral address space.
// I/O: zero-extend the low IO_AW bits.
// Legacy BIOS memory: keep LEGACY_KEEP bits and set the rest.
// Other memory: keep the low PERIPH_AW bits.
// Assumes legacy_i is the legacy-zone hit flag of the same transaction.
module zcs_addr_xlate #(
    parameter int unsigned HOST_AW     = 32,
    parameter int unsigned PERIPH_AW   = 28,
    parameter int unsigned IO_AW       = 16,
    parameter int unsigned LEGACY_KEEP = 17
) (
    input  logic                 is_mem_i,
    input  logic                 legacy_i,
    input  logic [HOST_AW-1:0]   addr_i,
    output logic [PERIPH_AW-1:0] xaddr_o
);

    localparam int unsigned IO_PAD  = PERIPH_AW - IO_AW;
    localparam int unsigned LEG_PAD = PERIPH_AW - LEGACY_KEEP;

    logic [PERIPH_AW-1:0] io_addr;
    logic [PERIPH_AW-1:0] legacy_addr;
    logic [PERIPH_AW-1:0] flat_addr;
    logic                 unused_hi_bits;

    assign io_addr        = {{IO_PAD{1'b0}}, addr_i[IO_AW-1:0]};
    assign legacy_addr    = {{LEG_PAD{1'b1}}, addr_i[LEGACY_KEEP-1:0]};
    assign flat_addr      = addr_i[PERIPH_AW-1:0];
    assign unused_hi_bits = ^addr_i[HOST_AW-1:PERIPH_AW];

    // Choose the rewrite by transaction type, then by zone.
    always_comb begin
        if (!is_mem_i) begin
            xaddr_o = io_addr;
        end else if (legacy_i) begin
            xaddr_o = legacy_addr;
        end else begin
            xaddr_o = flat_addr;
        end
    end

endmodule

// File: rtl/zone_cs_xlate.sv
// Module zone_cs_xlate (top)
// Claims a decoded host transaction for one of NUM_CS chip selects.
// It produces the registered select vector, a one-clock claim pulse and the
// translated peripheral address.
// Assumes the zone decoder output is valid in the same cycle as req_valid.
module zone_cs_xlate #(
    parameter int unsigned NUM_CS      = 2,
    parameter int unsigned HOST_AW     = 32,
    parameter int unsigned PERIPH_AW   = 28,
    parameter int unsigned IO_AW       = 16,
    parameter int unsigned LEGACY_KEEP = 17,
    localparam int unsigned NUM_ZONES  = zcs_pkg::NUM_ZONES,
    localparam int unsigned MAP_W      = zcs_pkg::MAP_W,
    localparam int unsigned WORD_W     = NUM_CS * MAP_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_is_mem,
    input  logic [HOST_AW-1:0]   req_addr,
    input  logic [NUM_ZONES-1:0] zone_hit,
    input  logic                 map_wr_en,
    input  logic [WORD_W-1:0]    map_wr_data,
    output logic [NUM_CS-1:0]    cs_o,
    output logic                 claim_o,
    output logic [PERIPH_AW-1:0] xaddr_o
);

    logic [WORD_W-1:0]    map_cur;
    logic [NUM_CS-1:0]    sel_d;
    logic                 any_d;
    logic [PERIPH_AW-1:0] xaddr_d;

    logic [NUM_CS-1:0]    cs_q;
    logic                 claim_q;
    logic [PERIPH_AW-1:0] xaddr_q;

    zcs_map_reg #(
        .NUM_CS (NUM_CS),
        .MAP_W  (MAP_W)
    ) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (map_wr_en),
        .wr_data (map_wr_data),
        .map_o   (map_cur)
    );

    zcs_select #(
        .NUM_CS    (NUM_CS),
        .NUM_ZONES (NUM_ZONES),
        .MAP_W     (MAP_W)
    ) u_sel (
        .map_i      (map_cur),
        .zone_hit_i (zone_hit),
        .sel_o      (sel_d),
        .any_o      (any_d)
    );

    zcs_addr_xlate #(
        .HOST_AW     (HOST_AW),
        .PERIPH_AW   (PERIPH_AW),
        .IO_AW       (IO_AW),
        .LEGACY_KEEP (LEGACY_KEEP)
    ) u_xlate (
        .is_mem_i (req_is_mem),
        .legacy_i (zone_hit[zcs_pkg::ZONE_LEGACY]),
        .addr_i   (req_addr),
        .xaddr_o  (xaddr_d)
    );

    // Output stage: pulse claim and select for one clock per claimed strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q    <= '0;
            claim_q <= 1'b0;
        end else begin
            cs_q    <= req_valid ? sel_d : '0;
            claim_q <= req_valid & any_d;
        end
    end

    // Address register: load on a claimed strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xaddr_q <= '0;
        end else if (req_valid && any_d) begin
            xaddr_q <= xaddr_d;
        end
    end

    assign cs_o    = cs_q;
    assign claim_o = claim_q;
    assign xaddr_o = xaddr_q;

endmodule

// File: rtl/zcs_checker.sv
// Module zcs_checker
// Property checks for zone_cs_xlate, attached to it by bind.
// Looks only at the top ports.
module zcs_checker #(
    parameter int unsigned NUM_CS      = 2,
    parameter int unsigned HOST_AW     = 32,
    parameter int unsigned PERIPH_AW   = 28,
    parameter int unsigned IO_AW       = 16,
    parameter int unsigned LEGACY_KEEP = 17,
    parameter int unsigned NUM_ZONES   = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_is_mem,
    input logic [HOST_AW-1:0]   req_addr,
    input logic [NUM_ZONES-1:0] zone_hit,
    input logic [NUM_CS-1:0]    cs_o,
    input logic                 claim_o,
    input logic [PERIPH_AW-1:0] xaddr_o
);

    // R3: at most one select at a time.
    p_cs_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o));

    // R8: no strobe means no claim and no select at the following edge.
    p_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!claim_o && cs_o == '0));

    // R4: with no claim, the address holds.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !claim_o |-> $stable(xaddr_o));

    // R5: a claimed I/O strobe yields a zero-extended address.
    p_io_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_mem) |=>
            (!claim_o || (xaddr_o == {{(PERIPH_AW-IO_AW){1'b0}}, $past(req_addr[IO_AW-1:0])})));

    // R7: a claimed legacy memory strobe sets the upper bits.
    p_legacy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_mem && zone_hit[NUM_ZONES-1]) |=>
            (!claim_o || (xaddr_o == {{(PERIPH_AW-LEGACY_KEEP){1'b1}}, $past(req_addr[LEGACY_KEEP-1:0])})));

    // R2: a select is asserted only together with a claim.
    p_cs_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_o != '0) |-> claim_o);

endmodule

bind zone_cs_xlate zcs_checker #(
    .NUM_CS      (NUM_CS),
    .HOST_AW     (HOST_AW),
    .PERIPH_AW   (PERIPH_AW),
    .IO_AW       (IO_AW),
    .LEGACY_KEEP (LEGACY_KEEP),
    .NUM_ZONES   (NUM_ZONES)
) u_zcs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_is_mem (req_is_mem),
    .req_addr   (req_addr),
    .zone_hit   (zone_hit),
    .cs_o       (cs_o),
    .claim_o    (claim_o),
    .xaddr_o    (xaddr_o)
);

// File: tb/zone_cs_xlate_tb_top.sv
// Bench for zone_cs_xlate: a table of vectors, then directed reset and corner cases.
module zone_cs_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_mem = 1'b0;
    logic [31:0] req_addr = '0;
    logic [4:0]  zone_hit = '0;
    logic        map_wr_en = 1'b0;
    logic [5:0]  map_wr_data = '0;
    logic [1:0]  cs_o;
    logic        claim_o;
    logic [27:0] xaddr_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    zone_cs_xlate dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_is_mem  (req_is_mem),
        .req_addr    (req_addr),
        .zone_hit    (zone_hit),
        .map_wr_en   (map_wr_en),
        .map_wr_data (map_wr_data),
        .cs_o        (cs_o),
        .claim_o     (claim_o),
        .xaddr_o     (xaddr_o)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        is_mem;
        logic [31:0] addr;
        logic [4:0]  hit;
        logic [5:0]  map;
        logic        claim;
        logic [1:0]  cs;
        logic [27:0] xaddr;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'd5,  1'b0, 32'h1234_03F8, 5'b00001, 6'o01, 1'b1, 2'b01, 28'h00003F8}, // R5 R2 cs0 on I/O zone A
        '{4'd2,  1'b0, 32'h0000_ABCD, 5'b00010, 6'o21, 1'b1, 2'b10, 28'h000ABCD}, // R2 cs1 on I/O zone B
        '{4'd3,  1'b1, 32'hF123_4567, 5'b00100, 6'o33, 1'b1, 2'b01, 28'h1234567}, // R3 R6 both on user zone
        '{4'd6,  1'b1, 32'hFFC0_1234, 5'b01000, 6'o40, 1'b1, 2'b10, 28'hFC01234}, // R6 386 BIOS zone
        '{4'd7,  1'b1, 32'h000F_FFF0, 5'b10000, 6'o05, 1'b1, 2'b01, 28'hFFFFFF0}, // R7 legacy
        '{4'd7,  1'b1, 32'h000E_0010, 5'b10000, 6'o55, 1'b1, 2'b01, 28'hFFE0010}, // R7 R3 legacy, both selects
        '{4'd4,  1'b1, 32'h0ABC_DEF0, 5'b00100, 6'o12, 1'b0, 2'b00, 28'hFFE0010}, // R4 unmapped zone, hold
        '{4'd10, 1'b1, 32'h0000_1111, 5'b10000, 6'o76, 1'b0, 2'b00, 28'hFFE0010}, // R10 codes 6 and 7
        '{4'd10, 1'b0, 32'h0000_2222, 5'b00001, 6'o00, 1'b0, 2'b00, 28'hFFE0010}, // R10 code 0
        '{4'd5,  1'b0, 32'hFFFF_FFFF, 5'b00001, 6'o10, 1'b1, 2'b10, 28'h000FFFF}  // R5 upper bits dropped
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_map(input logic [5:0] m);
        @(negedge clk);
        map_wr_en   = 1'b1;
        map_wr_data = m;
        @(negedge clk);
        map_wr_en   = 1'b0;
    endtask

    // Drive one strobe at a falling edge, then read the outputs at the next falling edge.
    task automatic strobe(input logic is_mem, input logic [31:0] a, input logic [4:0] h);
        req_is_mem = is_mem;
        req_addr   = a;
        zone_hit   = h;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 claim", 32'(claim_o), 32'd0);
        check("R1 cs", 32'(cs_o), 32'd0);
        check("R1 xaddr", 32'(xaddr_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: the map resets to none, so an I/O zone A hit is not claimed
        strobe(1'b0, 32'h0000_0060, 5'b00001);
        check("R1 map none claim", 32'(claim_o), 32'd0);

        for (int i = 0; i < NV; i++) begin
            write_map(VECS[i].map);
            strobe(VECS[i].is_mem, VECS[i].addr, VECS[i].hit);
            check($sformatf("R%0d row%0d claim", VECS[i].req, i), 32'(claim_o), 32'(VECS[i].claim));
            check($sformatf("R%0d row%0d cs", VECS[i].req, i), 32'(cs_o), 32'(VECS[i].cs));
            check($sformatf("R%0d row%0d xaddr", VECS[i].req, i), 32'(xaddr_o), 32'(VECS[i].xaddr));
            @(negedge clk);
            // R8: the pulse lasts one clock
            check($sformatf("R8 row%0d pulse end", i), 32'({claim_o, cs_o}), 32'd0);
        end

        // R8: a zone hit without a strobe claims nothing
        write_map(6'o01);
        zone_hit = 5'b00001;
        req_is_mem = 1'b0;
        @(negedge clk);
        check("R8 no strobe", 32'({claim_o, cs_o}), 32'd0);

        // R9: a map write at the same edge as a strobe uses the old map (none)
        write_map(6'o00);
        map_wr_en   = 1'b1;
        map_wr_data = 6'o01;
        strobe(1'b0, 32'h0000_0378, 5'b00001);
        map_wr_en   = 1'b0;
        check("R9 old map claim", 32'(claim_o), 32'd0);
        @(negedge clk);
        strobe(1'b0, 32'h0000_0378, 5'b00001);
        check("R9 new map claim", 32'(claim_o), 32'd1);
        check("R9 new map cs", 32'(cs_o), 32'd1);
        check("R9 new map xaddr", 32'(xaddr_o), 32'h0000378);

        // R1: a reset in mid-run clears the outputs again
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 rerun xaddr", 32'(xaddr_o), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule